// File: doc/BRIEF.md
# CAN Controller Mode and Interrupt Register Block

This block is the software-facing control and status part of a CAN controller. A simple 32-bit register port lets software enable the controller, select its operating mode, read a one-hot mode status word, and read and acknowledge the transmit-done and receive-done interrupt flags. It also holds the transmit frame (identifier word, length word and two data words) that software fills in, and the receive frame that the block captures.

Bit-level serialization, arbitration, CRC and bit timing are not part of this block. A frame-level port stands in for the bus. A launched frame leaves as a one-cycle valid pulse that carries four words. A frame arriving from the bus enters as a one-cycle valid pulse with four words. The operating mode is one of five: configuration, normal, loopback, snoop or sleep. A mode can only be chosen from configuration. In loopback a launched frame comes straight back into the receive registers. A sleeping node wakes on the first frame it sees.

Top module: `canctl_regs`

## Requirements
- R1: After reset the block is in configuration mode. The status word (offset 0x18), the interrupt status word (offset 0x1C) and the enable register (offset 0x00) all read 0, and no bus frame is launched.
- R2: The mode code is written at offset 0x04 while in configuration mode, and then bit 1 is set at offset 0x00. Code 0 gives normal (status bit 3), code 1 gives sleep (status bit 2), code 2 gives loopback (status bit 1) and code 4 gives snoop (status bit 12). Any other code gives normal. The status word never has more than one bit set.
- R3: A write to the mode code while the controller is enabled is ignored. Writing 0 to bit 1 of offset 0x00 returns the block to configuration mode, where the status word reads 0.
- R4: In normal mode, a write to the second transmit data word (offset 0x3C) launches the frame. The outputs carry the words held at 0x30/0x34/0x38 and the value just written. The bus valid output is high for exactly one cycle, and interrupt status bit 1 (transmit done) is set.
- R5: While the block is in configuration mode, writes to the transmit words (0x30 to 0x3C) are ignored. The words read back unchanged and nothing is launched.
- R6: A bus frame accepted in normal mode is stored in the receive words at 0x50/0x54/0x58/0x5C. The length word at 0x54 holds the incoming length word plus the timestamp value TSTAMP (default 1). Interrupt status bit 4 (receive done) is set.
- R7: A write to offset 0x24 clears each interrupt flag whose bit position (1 or 4) is written as 1. Other bits have no effect. A flag set in the same cycle as its clear stays set.
- R8: In loopback mode, a launch copies the transmit words unchanged into the receive words and sets both interrupt flags. Nothing goes out on the bus, and frames arriving from the bus are ignored.
- R9: In sleep mode, a write to offset 0x3C launches nothing. A frame arriving from the bus moves the block to normal mode (status bit 3), and the frame is stored as in R6.
- R10: In snoop mode, bus frames are received as in R6. The bus valid output is never raised, and transmit done is not set.
- R11: Each accepted frame overwrites the receive words, including frames that arrive before software has cleared the receive flag.
- R12: In configuration mode, bus frames are ignored. The receive words and the interrupt flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data for reg_addr (combinational) |
| bus_tx_valid | output | 1 | One-cycle pulse: a frame goes to the bus |
| bus_tx_id | output | W | Identifier word of the outgoing frame |
| bus_tx_dlc | output | W | Length word of the outgoing frame |
| bus_tx_data0 | output | W | First data word of the outgoing frame |
| bus_tx_data1 | output | W | Second data word of the outgoing frame |
| bus_rx_valid | input | 1 | One-cycle pulse: a frame arrives from the bus |
| bus_rx_id | input | W | Identifier word of the incoming frame |
| bus_rx_dlc | input | W | Length word of the incoming frame |
| bus_rx_data0 | input | W | First data word of the incoming frame |
| bus_rx_data1 | input | W | Second data word of the incoming frame |

## Verification
The mode selection is swept over all eight mode codes. This separates the four defined encodings from the fall-back to normal, and shows that writes to the mode register while enabled are ignored. Frames with distinct word patterns are sent and received in every mode. These frames show where a frame is routed: to the bus, back into its own receive words, or nowhere. They also show whether the timestamp is added, whether a sleeping node wakes, and whether a newer frame overwrites an older one. All four combinations of the interrupt clear mask are applied with both flags set. A clear is also issued in the same cycle as a new receive, to show that the set wins.

// File: rtl/canctl_pkg.sv
package canctl_pkg;

  typedef enum logic [2:0] {
    MD_CFG    = 3'd0,
    MD_NORMAL = 3'd1,
    MD_LOOP   = 3'd2,
    MD_SNOOP  = 3'd3,
    MD_SLEEP  = 3'd4
  } mode_e;

  // register byte offsets
  localparam int OFF_ENABLE = 'h00;
  localparam int OFF_MODE   = 'h04;
  localparam int OFF_STATUS = 'h18;
  localparam int OFF_ISR    = 'h1C;
  localparam int OFF_ICLR   = 'h24;
  localparam int OFF_TXBASE = 'h30;
  localparam int OFF_RXBASE = 'h50;

  localparam int FRAME_WORDS = 4;
  localparam int TX_LAST     = FRAME_WORDS - 1;

  // bit positions
  localparam int EN_BIT      = 1;
  localparam int ST_LOOP     = 1;
  localparam int ST_SLEEP    = 2;
  localparam int ST_NORMAL   = 3;
  localparam int ST_SNOOP    = 12;
  localparam int IRQ_TX_BIT  = 1;
  localparam int IRQ_RX_BIT  = 4;

  function automatic mode_e mode_from_code(input logic [2:0] code);
    case (code)
      3'd1:    return MD_SLEEP;
      3'd2:    return MD_LOOP;
      3'd4:    return MD_SNOOP;
      default: return MD_NORMAL;
    endcase
  endfunction

endpackage

// File: rtl/canctl_mode_ctrl.sv
module canctl_mode_ctrl
  import canctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_we,
  input  logic       en_bit,
  input  logic       code_we,
  input  logic [2:0] code_in,
  input  logic       wake,
  output mode_e      mode_q,
  output logic [2:0] code_q
);

  mode_e      mode_d;
  logic [2:0] code_d;

  always_comb begin
    mode_d = mode_q;
    code_d = code_q;
    if (code_we && mode_q == MD_CFG) begin
      code_d = code_in;
    end
    if (en_we) begin
      if (!en_bit) begin
        mode_d = MD_CFG;
      end else if (mode_q == MD_CFG) begin
        mode_d = mode_from_code(code_q);
      end
    end else if (wake && mode_q == MD_SLEEP) begin
      mode_d = MD_NORMAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_CFG;
      code_q <= 3'd0;
    end else begin
      mode_q <= mode_d;
      code_q <= code_d;
    end
  end

endmodule

// File: rtl/canctl_irq_flags.sv
module canctl_irq_flags #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] clr_i,
  output logic [NFLAG-1:0] flag_q
);

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic nxt;
    assign nxt = set_i[g] | (flag_q[g] & ~clr_i[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= nxt;
    end
  end

endmodule

// File: rtl/canctl_frame_store.sv
module canctl_frame_store #(
  parameter int W      = 32,
  parameter int NW     = 4,
  parameter int TSTAMP = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NW-1:0]       tx_we,
  input  logic [W-1:0]        wdata,
  input  logic                launch_bus,
  input  logic                launch_loop,
  input  logic                rx_accept,
  input  logic [NW-1:0][W-1:0] rx_words_in,
  output logic [NW-1:0][W-1:0] tx_q,
  output logic [NW-1:0][W-1:0] rx_q,
  output logic                tx_valid_q
);

  localparam logic [W-1:0] TS_W = W'(TSTAMP);

  logic [NW-1:0][W-1:0] tx_d;
  logic [NW-1:0][W-1:0] rx_d;
  logic                 rx_load;

  always_comb begin
    for (int k = 0; k < NW; k++) begin
      tx_d[k] = tx_we[k] ? wdata : tx_q[k];
    end
    rx_load = launch_loop | rx_accept;
    if (launch_loop) begin
      rx_d = tx_d;
    end else begin
      rx_d    = rx_words_in;
      rx_d[1] = rx_words_in[1] + TS_W;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q       <= '0;
      rx_q       <= '0;
      tx_valid_q <= 1'b0;
    end else begin
      tx_q       <= tx_d;
      tx_valid_q <= launch_bus;
      if (rx_load) rx_q <= rx_d;
    end
  end

endmodule

// File: rtl/canctl_regs.sv
module canctl_regs
  import canctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int W      = 32,
  parameter int TSTAMP = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic              bus_tx_valid,
  output logic [W-1:0]      bus_tx_id,
  output logic [W-1:0]      bus_tx_dlc,
  output logic [W-1:0]      bus_tx_data0,
  output logic [W-1:0]      bus_tx_data1,
  input  logic              bus_rx_valid,
  input  logic [W-1:0]      bus_rx_id,
  input  logic [W-1:0]      bus_rx_dlc,
  input  logic [W-1:0]      bus_rx_data0,
  input  logic [W-1:0]      bus_rx_data1
);

  localparam int NW = FRAME_WORDS;

  mode_e                mode_q;
  logic [2:0]           code_q;
  logic                 en_we, code_we, clr_we;
  logic [NW-1:0]        tx_we;
  logic                 may_send, launch, launch_bus, launch_loop, rx_accept;
  logic [1:0]           flag_set, flag_clr, flags_q;
  logic [NW-1:0][W-1:0] tx_q, rx_q, rx_words_in;
  logic [W-1:0]         status_w;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  always_comb begin
    en_we    = reg_we && hit(reg_addr, OFF_ENABLE);
    code_we  = reg_we && hit(reg_addr, OFF_MODE);
    clr_we   = reg_we && hit(reg_addr, OFF_ICLR);
    for (int k = 0; k < NW; k++) begin
      tx_we[k] = reg_we && (mode_q != MD_CFG) && hit(reg_addr, OFF_TXBASE + 4*k);
    end
    may_send    = (mode_q == MD_NORMAL) || (mode_q == MD_LOOP);
    launch      = tx_we[TX_LAST] && may_send;
    launch_bus  = launch && (mode_q == MD_NORMAL);
    launch_loop = launch && (mode_q == MD_LOOP);
    rx_accept   = bus_rx_valid &&
                  (mode_q == MD_NORMAL || mode_q == MD_SNOOP || mode_q == MD_SLEEP);
    flag_set    = {rx_accept | launch_loop, launch};
    flag_clr    = {clr_we & reg_wdata[IRQ_RX_BIT], clr_we & reg_wdata[IRQ_TX_BIT]};
    rx_words_in = {bus_rx_data1, bus_rx_data0, bus_rx_dlc, bus_rx_id};
  end

  canctl_mode_ctrl u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_we   (en_we),
    .en_bit  (reg_wdata[EN_BIT]),
    .code_we (code_we),
    .code_in (reg_wdata[2:0]),
    .wake    (bus_rx_valid),
    .mode_q  (mode_q),
    .code_q  (code_q)
  );

  canctl_irq_flags #(.NFLAG(2)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_q (flags_q)
  );

  canctl_frame_store #(.W(W), .NW(NW), .TSTAMP(TSTAMP)) u_frames (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_we       (tx_we),
    .wdata       (reg_wdata),
    .launch_bus  (launch_bus),
    .launch_loop (launch_loop),
    .rx_accept   (rx_accept),
    .rx_words_in (rx_words_in),
    .tx_q        (tx_q),
    .rx_q        (rx_q),
    .tx_valid_q  (bus_tx_valid)
  );

  assign bus_tx_id    = tx_q[0];
  assign bus_tx_dlc   = tx_q[1];
  assign bus_tx_data0 = tx_q[2];
  assign bus_tx_data1 = tx_q[3];

  always_comb begin
    status_w = '0;
    case (mode_q)
      MD_NORMAL: status_w[ST_NORMAL] = 1'b1;
      MD_LOOP:   status_w[ST_LOOP]   = 1'b1;
      MD_SNOOP:  status_w[ST_SNOOP]  = 1'b1;
      MD_SLEEP:  status_w[ST_SLEEP]  = 1'b1;
      default:   status_w = '0;
    endcase
  end

  always_comb begin
    reg_rdata = '0;
    if (hit(reg_addr, OFF_ENABLE)) reg_rdata[EN_BIT] = (mode_q != MD_CFG);
    if (hit(reg_addr, OFF_MODE))   reg_rdata[2:0]    = code_q;
    if (hit(reg_addr, OFF_STATUS)) reg_rdata         = status_w;
    if (hit(reg_addr, OFF_ISR)) begin
      reg_rdata[IRQ_TX_BIT] = flags_q[0];
      reg_rdata[IRQ_RX_BIT] = flags_q[1];
    end
    for (int k = 0; k < NW; k++) begin
      if (hit(reg_addr, OFF_TXBASE + 4*k)) reg_rdata = tx_q[k];
      if (hit(reg_addr, OFF_RXBASE + 4*k)) reg_rdata = rx_q[k];
    end
  end

endmodule

// File: rtl/canctl_regs_chk.sv
module canctl_regs_chk
  import canctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int W      = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [W-1:0]      reg_wdata,
  input logic              bus_rx_valid,
  input logic              bus_tx_valid,
  input logic [W-1:0]      status_w,
  input logic [1:0]        flags_q,
  input mode_e             mode_q
);

  logic wr_en_reg, wr_clr;
  assign wr_en_reg = reg_we && reg_addr == ADDR_W'(OFF_ENABLE);
  assign wr_clr    = reg_we && reg_addr == ADDR_W'(OFF_ICLR);

  assert_status_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status_w));

  assert_disable_to_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_reg && !reg_wdata[EN_BIT]) |=> (status_w == '0));

  assert_launch_flags_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_tx_valid |-> flags_q[0]);

  assert_clear_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && reg_wdata[IRQ_RX_BIT] && !bus_rx_valid) |=> !flags_q[1]);

  assert_clear_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && reg_wdata[IRQ_TX_BIT]) |=> !flags_q[0]);

  assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_SLEEP && bus_rx_valid && !wr_en_reg) |=> status_w[ST_NORMAL]);

  assert_snoop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_SNOOP) |=> !bus_tx_valid);

endmodule

bind canctl_regs canctl_regs_chk #(.ADDR_W(ADDR_W), .W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_we       (reg_we),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .bus_rx_valid (bus_rx_valid),
  .bus_tx_valid (bus_tx_valid),
  .status_w     (status_w),
  .flags_q      (flags_q),
  .mode_q       (mode_q)
);

// File: tb/sim_canctl_regs.sv
`timescale 1ns/1ps
module sim_canctl_regs;

  localparam int AW = 8;
  localparam int W  = 32;
  localparam logic [7:0] A_EN = 8'h00, A_MD = 8'h04, A_ST = 8'h18, A_IS = 8'h1C,
                         A_IC = 8'h24, A_T0 = 8'h30, A_T1 = 8'h34, A_T2 = 8'h38,
                         A_T3 = 8'h3C, A_R0 = 8'h50, A_R1 = 8'h54, A_R2 = 8'h58,
                         A_R3 = 8'h5C;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_we;
  logic [AW-1:0] reg_addr;
  logic [W-1:0] reg_wdata, reg_rdata;
  logic bus_tx_valid, bus_rx_valid;
  logic [W-1:0] tx_id, tx_dlc, tx_d0, tx_d1;
  logic [W-1:0] rx_id, rx_dlc, rx_d0, rx_d1;

  int checks = 0, failures = 0, tx_count = 0;
  logic [W-1:0] cap [4];

  always #2.5 clk = ~clk;

  canctl_regs #(.ADDR_W(AW), .W(W), .TSTAMP(1)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_tx_valid(bus_tx_valid), .bus_tx_id(tx_id), .bus_tx_dlc(tx_dlc),
    .bus_tx_data0(tx_d0), .bus_tx_data1(tx_d1),
    .bus_rx_valid(bus_rx_valid), .bus_rx_id(rx_id), .bus_rx_dlc(rx_dlc),
    .bus_rx_data0(rx_d0), .bus_rx_data1(rx_d1));

  always @(negedge clk) begin
    if (bus_tx_valid) begin
      tx_count++;
      cap[0] = tx_id; cap[1] = tx_dlc; cap[2] = tx_d0; cap[3] = tx_d1;
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [W-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic chk_reg(input string tag, input logic [7:0] a, input logic [W-1:0] exp);
    logic [W-1:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic rx_frame(input logic [W-1:0] i, input logic [W-1:0] l,
                          input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    bus_rx_valid = 1'b1; rx_id = i; rx_dlc = l; rx_d0 = a; rx_d1 = b;
    @(negedge clk);
    bus_rx_valid = 1'b0;
  endtask

  task automatic tx_frame(input logic [W-1:0] i, input logic [W-1:0] l,
                          input logic [W-1:0] a, input logic [W-1:0] b);
    wr(A_T0, i); wr(A_T1, l); wr(A_T2, a); wr(A_T3, b);
  endtask

  task automatic set_mode(input logic [2:0] code);
    wr(A_EN, 0); wr(A_MD, W'(code)); wr(A_EN, 32'h2);
  endtask

  task automatic chk_rx(input string tag, input logic [W-1:0] i, input logic [W-1:0] l,
                        input logic [W-1:0] a, input logic [W-1:0] b);
    chk_reg(tag, A_R0, i); chk_reg(tag, A_R1, l);
    chk_reg(tag, A_R2, a); chk_reg(tag, A_R3, b);
  endtask

  function automatic logic [W-1:0] st_of(input int code);
    case (code)
      1: return 32'h4;
      2: return 32'h2;
      4: return 32'h1000;
      default: return 32'h8;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    bus_rx_valid = 1'b0; rx_id = '0; rx_dlc = '0; rx_d0 = '0; rx_d1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_reg("R1 status", A_ST, 0);
    chk_reg("R1 isr", A_IS, 0);
    chk_reg("R1 enable", A_EN, 0);
    chk("R1 no tx", W'(tx_count), 0);

    // R5 tx writes ignored while disabled
    tx_frame(32'hAA, 32'hBB, 32'hCC, 32'hDD);
    chk_reg("R5 txid", A_T0, 0);
    chk_reg("R5 txd1", A_T3, 0);
    chk_reg("R5 isr", A_IS, 0);
    chk("R5 no tx", W'(tx_count), 0);

    // R12 config ignores bus frames
    rx_frame(32'h77, 32'h3, 32'h1, 32'h2);
    chk_rx("R12 rx", 0, 0, 0, 0);
    chk_reg("R12 isr", A_IS, 0);

    // R2 / R3 sweep over all mode codes
    for (int c = 0; c < 8; c++) begin
      set_mode(3'(c));
      chk_reg("R2 status", A_ST, st_of(c));
      chk_reg("R2 code", A_MD, W'(c));
      chk_reg("R2 enable", A_EN, 32'h2);
      wr(A_MD, W'(c ^ 7));
      chk_reg("R3 code kept", A_MD, W'(c));
      chk_reg("R3 status kept", A_ST, st_of(c));
      wr(A_EN, 0);
      chk_reg("R3 cfg status", A_ST, 0);
    end

    // R4 normal-mode launches
    set_mode(3'd0);
    for (int i = 0; i < 4; i++) begin
      base = tx_count;
      tx_frame(32'h100 + W'(i), W'(i + 2), 32'h12340000 + W'(i * 17), ~(32'h5A5A0000 + W'(i)));
      chk_reg("R4 isr", A_IS, 32'h2);
      chk("R4 one pulse", W'(tx_count), W'(base + 1));
      chk("R4 id", cap[0], 32'h100 + W'(i));
      chk("R4 dlc", cap[1], W'(i + 2));
      chk("R4 d0", cap[2], 32'h12340000 + W'(i * 17));
      chk("R4 d1", cap[3], ~(32'h5A5A0000 + W'(i)));
      wr(A_IC, 32'h2);
      chk_reg("R7 tx cleared", A_IS, 0);
    end

    // R6 / R11 bus receive and overwrite
    for (int j = 0; j < 3; j++) begin
      rx_frame(32'h200 + W'(j), 32'h80000000 + W'(j), 32'hA0 * W'(j + 1), 32'hFFFF0000 >> j);
      chk_rx("R6 R11 rx", 32'h200 + W'(j), 32'h80000001 + W'(j), 32'hA0 * W'(j + 1), 32'hFFFF0000 >> j);
      chk_reg("R6 isr", A_IS, 32'h10);
    end

    // R7 clear mask sweep
    for (int m = 0; m < 4; m++) begin
      tx_frame(1, 2, 3, 4);
      rx_frame(5, 6, 7, 8);
      wr(A_IC, (m[0] ? 32'h2 : 0) | (m[1] ? 32'h10 : 0));
      chk_reg("R7 mask", A_IS, 32'h12 & ~((m[0] ? 32'h2 : 0) | (m[1] ? 32'h10 : 0)));
    end
    tx_frame(1, 2, 3, 4);
    rx_frame(5, 6, 7, 8);
    wr(A_IC, 32'hFFFFFFED);
    chk_reg("R7 other bits", A_IS, 32'h12);
    wr(A_IC, 32'h12);
    // R7 set wins over clear
    @(negedge clk);
    reg_we = 1'b1; reg_addr = A_IC; reg_wdata = 32'h10;
    bus_rx_valid = 1'b1; rx_id = 9; rx_dlc = 9; rx_d0 = 9; rx_d1 = 9;
    @(negedge clk);
    reg_we = 1'b0; bus_rx_valid = 1'b0;
    chk_reg("R7 set wins", A_IS, 32'h10);
    wr(A_IC, 32'h12);

    // R8 loopback
    set_mode(3'd2);
    base = tx_count;
    tx_frame(32'hFF, 32'h80000000, 32'h12345678, 32'h87654321);
    chk_rx("R8 loop rx", 32'hFF, 32'h80000000, 32'h12345678, 32'h87654321);
    chk_reg("R8 isr", A_IS, 32'h12);
    chk("R8 no bus", W'(tx_count), W'(base));
    rx_frame(32'h33, 32'h33, 32'h33, 32'h33);
    chk_rx("R8 bus ignored", 32'hFF, 32'h80000000, 32'h12345678, 32'h87654321);
    wr(A_IC, 32'h12);

    // R9 sleep and wake
    set_mode(3'd1);
    base = tx_count;
    tx_frame(32'h44, 1, 2, 3);
    chk_reg("R9 no launch isr", A_IS, 0);
    chk("R9 no launch", W'(tx_count), W'(base));
    rx_frame(32'h14, 32'h80000000, 32'h12345678, 32'h87654321);
    chk_reg("R9 woke", A_ST, 32'h8);
    chk_rx("R9 rx", 32'h14, 32'h80000001, 32'h12345678, 32'h87654321);
    chk_reg("R9 isr", A_IS, 32'h10);
    wr(A_IC, 32'h12);

    // R10 snoop
    set_mode(3'd4);
    base = tx_count;
    tx_frame(32'h55, 1, 2, 3);
    chk_reg("R10 no txok", A_IS, 0);
    chk("R10 silent", W'(tx_count), W'(base));
    rx_frame(32'h66, 32'h10, 32'hDEAD, 32'hBEEF);
    chk_rx("R10 rx", 32'h66, 32'h11, 32'hDEAD, 32'hBEEF);
    chk_reg("R10 isr", A_IS, 32'h10);
    chk_reg("R10 status", A_ST, 32'h1000);

    // R12 again with flags set
    wr(A_EN, 0);
    rx_frame(32'h99, 32'h99, 32'h99, 32'h99);
    chk_rx("R12 cfg rx", 32'h66, 32'h11, 32'hDEAD, 32'hBEEF);
    chk_reg("R12 cfg isr", A_IS, 32'h10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule